// File: doc/BRIEF.md
# Dual-Half Hamming Parity Generator

This block sits beside the byte data path of a NAND flash host and builds single-error-correcting Hamming parity while a page streams past. A page of 512 bytes is taken as two separate halves of `HALF_BYTES` bytes each (256 by default). For each half it accumulates a 16-bit line parity and a 6-bit column parity. Decoding a syndrome and flipping a bad bit are left to software, which compares stored parity with a freshly generated set.

Software steers the block with one-byte mode commands. The value 0xF4 clears the accumulators. The value 0xB4 makes every following data byte count toward the parity. The value 0xD4 turns the 16-bit read port into a parity readout. In readout the six parity bytes come out as three 16-bit words, and the words are packed so that the bytes of the two halves interleave. Any other mode value pauses the block without losing state.

The controller is a five-state machine:

- IDLE: the state after reset and after any unrecognised mode.
- CLEARED: the state after 0xF4.
- CALC: the state in which bytes are accumulated.
- FULL: the state once all 512 bytes are in, or when 0xB4 arrives after the page is complete.
- READOUT: the state after 0xD4.

The transitions are:

- A mode write takes priority over everything else. 0xF4 goes to CLEARED, 0xD4 goes to READOUT, and any other value goes to IDLE.
- 0xB4 goes to CALC, or to FULL if the page-complete flag is already set.
- Without a mode write, CALC moves to FULL on the cycle that accepts the last byte of the page.
- All other states hold.

`HALF_BYTES` must be a power of two no larger than 256.

Top module: `dual_ecc_gen`

## Requirements
- R1: After reset, a readout gives the parity of an empty page: word 0 = 0x0000, word 1 = 0x0003, word 2 = 0x0300.
- R2: Writing mode 0xF4 zeroes both parity sets, the byte count and the page-complete flag. A byte offered in the same cycle as any mode write is not accumulated.
- R3: In CALC, each cycle with `xfer_valid` high adds `xfer_byte` to the parity. Page bytes 0 to HALF_BYTES-1 go only to the first set, and the remaining HALF_BYTES bytes go only to the second set.
- R4: Line parity bit 2k+1 is the XOR of the bit-parities of the bytes whose in-half index has bit k = 1. Line parity bit 2k is the same over the bytes whose index has bit k = 0. This holds for k = 0 to 7.
- R5: The column byte is {CP5..CP0, 1, 1}, so its two low bits are always 1. CP(2j+1) is the XOR of all data bits whose bit position has bit j = 1, and CP(2j) is the XOR of those whose position has bit j = 0, for j = 0 to 2.
- R6: In READOUT, with A the first half and B the second:
  - word 0 = {A.LP[7:0], A.LP[15:8]}
  - word 1 = {B.LP[15:8], A.CP}
  - word 2 = {B.CP, B.LP[7:0]}
- R7: In READOUT, `rd_word` shows the word at the read pointer, and each `rd_strobe` advances the pointer 0→1→2→0. Writing 0xD4 returns the pointer to word 0.
- R8: Outside CALC, neither `rd_strobe` nor offered bytes change the parity. This covers the dummy read after 0xF4 and bytes offered during READOUT.
- R9: After the 512th byte, further bytes leave the parity unchanged until 0xF4, even if 0xB4 is written again.
- R10: A mode value other than 0xF4, 0xB4 or 0xD4 enters IDLE and pauses accumulation. A later 0xB4 resumes at the same byte index.
- R11: `rd_word` is 0x0000 whenever the block is not in READOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode command write strobe |
| mode_cmd | input | 8 | Mode command value |
| xfer_valid | input | 1 | A data byte crosses the data path this cycle |
| xfer_byte | input | 8 | The data byte |
| rd_strobe | input | 1 | 16-bit data-register read; advances the readout pointer |
| rd_word | output | 16 | Parity readout word |

## Verification
The bench builds the block with its default `HALF_BYTES` of 256. This is the only setting at which the full 16-bit line parity, the 512-byte page boundary and the overflow beyond it are all reached. Within that build it exercises:

- pages of random bytes and pages of uniform bytes,
- a page with a single set bit in the second half,
- a short partial page,
- a page paused mid-stream by an unrelated mode,
- collisions between a mode write and a data byte.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEARED,
        ST_CALC,
        ST_FULL,
        ST_READOUT
    } ecc_state_t;

    localparam logic [7:0] CMD_RESET  = 8'hF4;
    localparam logic [7:0] CMD_CALC   = 8'hB4;
    localparam logic [7:0] CMD_RESULT = 8'hD4;
endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc #(
    parameter int ABITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [ABITS-1:0]   idx,
    input  logic [7:0]         din,
    output logic [2*ABITS-1:0] lp,
    output logic [7:0]         col
);
    logic               bit_par;
    logic [2*ABITS-1:0] lp_mask;

    assign bit_par = ^din;

    // Each address bit selects which bit of its pair absorbs the byte parity.
    generate
        for (genvar k = 0; k < ABITS; k++) begin : g_pair
            assign lp_mask[2*k+1] = bit_par & idx[k];
            assign lp_mask[2*k]   = bit_par & ~idx[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lp  <= '0;
            col <= '0;
        end else if (en) begin
            lp  <= lp ^ lp_mask;
            col <= col ^ din;
        end
    end
endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
    import ecc_pkg::*;
#(
    parameter int ABITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [7:0]       mode_cmd,
    input  logic             xfer_valid,
    output ecc_state_t       state,
    output logic             clr,
    output logic             acc_en,
    output logic             half_sel,
    output logic [ABITS-1:0] byte_idx
);
    logic [ABITS:0] cnt;
    logic           page_done;
    logic           last_byte;
    ecc_state_t     nxt;

    assign last_byte = &cnt;
    assign clr       = mode_we && (mode_cmd == CMD_RESET);
    assign acc_en    = (state == ST_CALC) && xfer_valid && !mode_we;
    assign half_sel  = cnt[ABITS];
    assign byte_idx  = cnt[ABITS-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt       <= '0;
            page_done <= 1'b0;
        end else if (acc_en) begin
            cnt <= cnt + 1'b1;
            if (last_byte) page_done <= 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        if (mode_we) begin
            unique case (mode_cmd)
                CMD_RESET:  nxt = ST_CLEARED;
                CMD_CALC:   nxt = page_done ? ST_FULL : ST_CALC;
                CMD_RESULT: nxt = ST_READOUT;
                default:    nxt = ST_IDLE;
            endcase
        end else begin
            unique case (state)
                ST_CALC:    if (xfer_valid && last_byte) nxt = ST_FULL;
                ST_IDLE, ST_CLEARED, ST_FULL, ST_READOUT: nxt = state;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // R9
    full_no_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !clr) |=> (state != ST_CALC));
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout #(
    parameter int ABITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               in_readout,
    input  logic               rd_strobe,
    input  logic [2*ABITS-1:0] lp_a,
    input  logic [7:0]         col_a,
    input  logic [2*ABITS-1:0] lp_b,
    input  logic [7:0]         col_b,
    output logic [15:0]        rd_word
);
    logic [1:0]  ptr;
    logic [15:0] lpa_x, lpb_x, word;
    logic [7:0]  cp_a, cp_b;

    function automatic logic [7:0] cp_byte(input logic [7:0] c);
        return {c[7]^c[6]^c[5]^c[4], c[3]^c[2]^c[1]^c[0],
                c[7]^c[6]^c[3]^c[2], c[5]^c[4]^c[1]^c[0],
                c[7]^c[5]^c[3]^c[1], c[6]^c[4]^c[2]^c[0],
                2'b11};
    endfunction

    assign lpa_x = 16'(lp_a);
    assign lpb_x = 16'(lp_b);
    assign cp_a  = cp_byte(col_a);
    assign cp_b  = cp_byte(col_b);

    always_ff @(posedge clk) begin
        if (!rst_n || restart)            ptr <= 2'd0;
        else if (in_readout && rd_strobe) ptr <= (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
    end

    always_comb begin
        unique case (ptr)
            2'd0:    word = {lpa_x[7:0], lpa_x[15:8]};
            2'd1:    word = {lpb_x[15:8], cp_a};
            2'd2:    word = {cp_b, lpb_x[7:0]};
            default: word = 16'h0000;
        endcase
    end

    assign rd_word = in_readout ? word : 16'h0000;

    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr != 2'd3);
    // R5
    cp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_readout && ptr == 2'd1) |-> (rd_word[1:0] == 2'b11));
endmodule

// File: rtl/dual_ecc_gen.sv
module dual_ecc_gen
    import ecc_pkg::*;
#(
    parameter int HALF_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_we,
    input  logic [7:0]  mode_cmd,
    input  logic        xfer_valid,
    input  logic [7:0]  xfer_byte,
    input  logic        rd_strobe,
    output logic [15:0] rd_word
);
    localparam int ABITS = $clog2(HALF_BYTES);
    localparam int LPW   = 2 * ABITS;

    ecc_state_t       state;
    logic             clr, acc_en, half_sel;
    logic [ABITS-1:0] byte_idx;
    logic [1:0]       half_en;
    logic [LPW-1:0]   lp  [2];
    logic [7:0]       col [2];

    ecc_ctrl #(.ABITS(ABITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_cmd(mode_cmd),
        .xfer_valid(xfer_valid), .state(state), .clr(clr), .acc_en(acc_en),
        .half_sel(half_sel), .byte_idx(byte_idx)
    );

    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            assign half_en[h] = acc_en && (half_sel == h[0]);
            ecc_half_acc #(.ABITS(ABITS)) u_acc (
                .clk(clk), .rst_n(rst_n), .clr(clr), .en(half_en[h]),
                .idx(byte_idx), .din(xfer_byte), .lp(lp[h]), .col(col[h])
            );
        end
    endgenerate

    ecc_readout #(.ABITS(ABITS)) u_out (
        .clk(clk), .rst_n(rst_n),
        .restart(mode_we && mode_cmd == CMD_RESULT),
        .in_readout(state == ST_READOUT), .rd_strobe(rd_strobe),
        .lp_a(lp[0]), .col_a(col[0]), .lp_b(lp[1]), .col_b(col[1]),
        .rd_word(rd_word)
    );

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CALC && !clr) |=>
        ($stable(lp[0]) && $stable(lp[1]) && $stable(col[0]) && $stable(col[1])));
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lp[0] == '0 && lp[1] == '0 && col[0] == '0 && col[1] == '0));
    // R3
    first_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC && !half_sel && !clr) |=> ($stable(lp[1]) && $stable(col[1])));
endmodule

// File: tb/dual_ecc_gen_test.sv
`timescale 1ns/1ps
module dual_ecc_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_cmd = 8'h00;
    logic        xfer_valid = 1'b0;
    logic [7:0]  xfer_byte = 8'h00;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_word;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] pg [512];

    always #2.5 clk = ~clk;

    dual_ecc_gen uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_cmd(mode_cmd),
        .xfer_valid(xfer_valid), .xfer_byte(xfer_byte), .rd_strobe(rd_strobe),
        .rd_word(rd_word)
    );

    function automatic logic [7:0] ref_cp(input logic [7:0] c);
        logic [7:0] r;
        r = 8'h03;
        for (int j = 0; j < 3; j++) begin
            for (int b = 0; b < 8; b++) begin
                if (b[j]) r[2*j+3] ^= c[b];
                else      r[2*j+2] ^= c[b];
            end
        end
        return r;
    endfunction

    // Expected {word2, word1, word0} over the first n bytes of pg.
    function automatic logic [47:0] ref_words(input int n);
        logic [15:0] lpr [2];
        logic [7:0]  cr  [2];
        lpr[0] = '0; lpr[1] = '0; cr[0] = '0; cr[1] = '0;
        for (int i = 0; i < n; i++) begin
            int h, ix;
            h  = i / 256;
            ix = i % 256;
            cr[h] ^= pg[i];
            for (int k = 0; k < 8; k++) begin
                if (ix[k]) lpr[h][2*k+1] ^= ^pg[i];
                else       lpr[h][2*k]   ^= ^pg[i];
            end
        end
        return {ref_cp(cr[1]), lpr[1][7:0],
                lpr[1][15:8], ref_cp(cr[0]),
                lpr[0][7:0], lpr[0][15:8]};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic [7:0] c);
        mode_we = 1'b1; mode_cmd = c;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        xfer_valid = 1'b1; xfer_byte = b;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic read_word(output logic [15:0] w);
        w = rd_word;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic check_readout(input string req, input int n);
        logic [47:0] e;
        logic [15:0] w;
        e = ref_words(n);
        set_mode(8'hD4);
        read_word(w); check({req, " w0"}, w, e[15:0]);
        read_word(w); check({req, " w1"}, w, e[31:16]);
        read_word(w); check({req, " w2"}, w, e[47:32]);
    endtask

    task automatic run_page(input int from, input int to);
        for (int i = from; i < to; i++) send(pg[i]);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: outside readout the port is zero
        check("R11 idle output", rd_word, 16'h0000);
        // R1: empty parity after reset
        for (int i = 0; i < 512; i++) pg[i] = 8'h00;
        check_readout("R1 reset readout", 0);

        // R3 R4 R5 R6: random pages, with dummy read (R8) after clear
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
            set_mode(8'hF4);
            read_word(w);                       // dummy read, R8
            check("R11 cleared output", w, 16'h0000);
            set_mode(8'hB4);
            run_page(0, 512);
            check_readout("R3 R4 R5 R6 random page", 512);
            // R7: wrap to first word, then restart on 0xD4
            read_word(w); check("R7 wrap", w, ref_words(512) >> 0);
            read_word(w);
            set_mode(8'hD4);
            check("R7 restart", rd_word, ref_words(512) >> 0);
        end

        // R9: extra bytes after a full page, even after 0xB4 again
        set_mode(8'hB4);
        for (int i = 0; i < 20; i++) send(8'($urandom));
        check_readout("R9 overflow ignored", 512);

        // R8: bytes offered during readout ignored
        for (int i = 0; i < 5; i++) send(8'hA5);
        check_readout("R8 bytes in readout", 512);

        // R10: pause mid-page with data mode, resume
        for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
        set_mode(8'hF4);
        set_mode(8'hB4);
        run_page(0, 100);
        set_mode(8'h94);
        check("R11 paused output", rd_word, 16'h0000);
        for (int i = 0; i < 10; i++) send(8'($urandom));
        set_mode(8'hB4);
        run_page(100, 512);
        check_readout("R10 pause resume", 512);

        // R2: clear with a colliding byte, then empty result
        set_mode(8'hB4);
        xfer_valid = 1'b1; xfer_byte = 8'hFF;
        set_mode(8'hF4);
        xfer_valid = 1'b0;
        for (int i = 0; i < 512; i++) pg[i] = 8'h00;
        set_mode(8'hB4);
        check_readout("R2 clear priority", 0);

        // R4 R5: single set bit in the second half
        pg[300] = 8'h20;
        set_mode(8'hF4);
        set_mode(8'hB4);
        run_page(0, 512);
        check_readout("R4 R5 single bit", 512);

        // R4 R5: all-ones page
        for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
        set_mode(8'hF4);
        set_mode(8'hB4);
        run_page(0, 512);
        check_readout("R4 R5 all ones", 512);

        // R3: partial page stays in the first half
        for (int i = 0; i < 512; i++) pg[i] = 8'($urandom);
        set_mode(8'hF4);
        set_mode(8'hB4);
        run_page(0, 3);
        check_readout("R3 partial page", 3);

        finish_run();
    end
endmodule